// File: doc/BRIEF.md
# Dual-Output PWM Timer Channel

This block is a 16-bit timer channel that drives two pulse-width outputs from a single counter. The counter advances on ticks from a shared divider that can slow the input clock by 1, 4, 16 or 64. Each output owns a pair of compare registers: one sets its period and one sets its high time. A control write sets the divider code, picks which output's period register clears the counter, and starts or stops counting. Each output also has its own enable.

A combinational helper sits beside the timer. It takes a requested period and high time, both counted in input clock cycles. It returns the smallest divider code that fits the request, and the period and high-time counts scaled to that code and saturated. When both outputs are active, the divider is shared and already in use. In that case the helper keeps the running code, and it flags a request that would need a coarser one.

Top module: `pwm2_timer`

## Requirements
- R1: After reset, `count` is 0 and both `pwm_out` bits are 0.
- R2: While the channel runs, `count` advances by one on each divider tick. The tick after `count` equals the active period register, `count` returns to 0. The active period register is register A (`cmp_addr` 0) when `ctl_clr_on_c` is 0, and register C (`cmp_addr` 2) when it is 1.
- R3: A divider code c on `ctl_prescale` gives one tick every 4^c input cycles. After the clock edge that starts the channel, `count` equals floor(n / 4^c) mod (P+1) at the n-th later edge.
- R4: Output 0 uses A as its period and B (`cmp_addr` 1) as its high time. Output 1 uses C as its period and D (`cmp_addr` 3) as its high time. An enabled output is high while `count` is below its high time. A high time of 0 keeps it low, and a high time equal to or above its own period keeps it high.
- R5: A compare write while running takes effect only at the next counter wrap to 0. While the channel is stopped, it takes effect on the next edge.
- R6: An output whose `out_en` bit is 0 stays low.
- R7: When both `out_en` bits are 0, or the run bit is 0, `count` is held at 0.
- R8: A control write that changes any control field while the channel runs clears the counter and the divider together. Counting then resumes under the new settings, as from a fresh start.
- R9: The helper's code is taken from q = `req_period` >> 16. The code is min((h+1)/2, 3), where h is the 1-based index of q's highest set bit, and h is 0 when q is 0.
- R10: `calc_period` equals `req_period` shifted right by twice the code and saturated to 0xFFFF. `calc_duty` is formed the same way from `req_duty` and then clamped so that it never exceeds `calc_period`.
- R11: When both `out_en` bits are 1, the helper returns the divider code currently in use. `calc_busy` is 1 exactly when the request needs a larger code than that one. Otherwise `calc_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_prescale | input | 2 | Divider code to write |
| ctl_clr_on_c | input | 1 | Clear source to write: 0 = register A, 1 = register C |
| ctl_run | input | 1 | Run bit to write |
| cmp_we | input | 1 | Compare write strobe |
| cmp_addr | input | 2 | Compare select: 0 A, 1 B, 2 C, 3 D |
| cmp_wdata | input | 16 | Compare value to write |
| out_en | input | 2 | Per-output enable |
| req_period | input | 32 | Helper: requested period in input cycles |
| req_duty | input | 32 | Helper: requested high time in input cycles |
| calc_code | output | 2 | Helper: chosen divider code |
| calc_period | output | 16 | Helper: scaled, saturated period count |
| calc_duty | output | 16 | Helper: scaled, clamped high-time count |
| calc_busy | output | 1 | Helper: request needs a coarser shared divider |
| count | output | 16 | Current counter value |
| pwm_out | output | 2 | Pulse-width outputs |

## Verification
The assertions watch the cycle-level invariants on every clock. The counter never passes the active period and sits at 0 when idle or after a restart. The divider never passes its limit. The staged compares stay frozen between ticks. A disabled output is low, an enabled output is high at count 0, and the helper's high time stays at or below its period with busy only when both outputs are active. Only the bench scenarios can show the full waveform against the floor(n/4^c) timing rule, the deferred pickup of a mid-period compare write, and the clean restart when the divider changes. The helper's arithmetic over random and boundary requests is also checked only there, as is the pairing of each output with its own registers.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int CNT_W = 16;
  localparam int PSC_W = 2;
  localparam int REQ_W = 32;
  localparam int NOUT  = 2;

  // compare register select; bit 1 = output pair, bit 0 = high-time register
  typedef enum logic [1:0] {
    CMP_PER0  = 2'd0,
    CMP_HIGH0 = 2'd1,
    CMP_PER1  = 2'd2,
    CMP_HIGH1 = 2'd3
  } cmp_sel_e;
endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler #(
  parameter int PSC_W = pwm2_pkg::PSC_W,
  parameter int DIV_W = 2 * ((1 << PSC_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  localparam int SH_W = PSC_W + 1;

  logic [DIV_W-1:0] dcnt;
  logic [DIV_W-1:0] limit;
  logic [SH_W-1:0]  shamt;

  assign shamt = {code, 1'b0};
  assign limit = ~({DIV_W{1'b1}} << shamt);
  assign tick  = enable && (dcnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)       dcnt <= '0;
    else if (!enable) dcnt <= '0;
    else if (tick)    dcnt <= '0;
    else              dcnt <= dcnt + 1'b1;
  end

  // R3: divider never passes 4^code - 1
  a_r3_div_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> dcnt <= limit);
endmodule

// File: rtl/pwm2_counter.sv
module pwm2_counter #(
  parameter int CNT_W = pwm2_pkg::CNT_W,
  parameter int NOUT  = pwm2_pkg::NOUT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmp_we,
  input  logic [1:0]                 cmp_addr,
  input  logic [CNT_W-1:0]           cmp_wdata,
  input  logic                       running,
  input  logic                       restart,
  input  logic                       tick,
  input  logic                       clr_on_c,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [NOUT-1:0][CNT_W-1:0] per_o,
  output logic [NOUT-1:0][CNT_W-1:0] high_o,
  output logic                       wrap_o
);
  logic [NOUT-1:0][CNT_W-1:0] stg_per, stg_high;
  logic [NOUT-1:0][CNT_W-1:0] sh_per, sh_high;
  logic [CNT_W-1:0]           cnt;
  logic [CNT_W-1:0]           top_val;
  logic                       at_top;
  logic                       load;

  genvar g;
  generate
    for (g = 0; g < NOUT; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_per[g]  <= '0;
          stg_high[g] <= '0;
        end else if (cmp_we && (cmp_addr[1] == g[0])) begin
          if (cmp_addr[0]) stg_high[g] <= cmp_wdata;
          else             stg_per[g]  <= cmp_wdata;
        end
      end
    end
  endgenerate

  assign top_val = sh_per[clr_on_c];
  assign at_top  = (cnt == top_val);
  assign wrap_o  = running && !restart && tick && at_top;
  assign load    = !running || restart || wrap_o;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (!running || restart) cnt <= '0;
    else if (tick)               cnt <= at_top ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_per  <= '0;
      sh_high <= '0;
    end else if (load) begin
      sh_per  <= stg_per;
      sh_high <= stg_high;
    end
  end

  assign cnt_o  = cnt;
  assign per_o  = sh_per;
  assign high_o = sh_high;

  // R2: counter never runs past the active period
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt <= top_val);
  // R5: live compares do not move between divider ticks
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !restart && !tick) |=> ($stable(sh_per) && $stable(sh_high)));
  // R7: an idle channel holds its counter at zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> cnt == '0);
endmodule

// File: rtl/pwm2_outstage.sv
module pwm2_outstage #(
  parameter int CNT_W = pwm2_pkg::CNT_W,
  parameter int NOUT  = pwm2_pkg::NOUT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CNT_W-1:0]           cnt,
  input  logic                       running,
  input  logic [NOUT-1:0]            en,
  input  logic [NOUT-1:0][CNT_W-1:0] per,
  input  logic [NOUT-1:0][CNT_W-1:0] high,
  output logic [NOUT-1:0]            pwm
);
  genvar g;
  generate
    for (g = 0; g < NOUT; g++) begin : g_out
      logic hold_high;
      assign hold_high = (high[g] >= per[g]);
      assign pwm[g] = en[g] && running && (hold_high || (cnt < high[g]));

      // R4: an enabled output is high at the start of every period
      a_r4_high_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en[g] && cnt == '0 && high[g] != '0) |-> pwm[g]);
      // R6: disabled output stays low
      a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en[g] |-> !pwm[g]);
    end
  endgenerate
endmodule

// File: rtl/pwm2_calc.sv
module pwm2_calc #(
  parameter int CNT_W = pwm2_pkg::CNT_W,
  parameter int PSC_W = pwm2_pkg::PSC_W,
  parameter int REQ_W = pwm2_pkg::REQ_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_W-1:0] req_period,
  input  logic [REQ_W-1:0] req_high,
  input  logic [PSC_W-1:0] cur_code,
  input  logic             shared,
  output logic [PSC_W-1:0] code_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] high_o,
  output logic             busy_o
);
  localparam int CODE_MAX = (1 << PSC_W) - 1;

  function automatic int unsigned msb_index(logic [REQ_W-1:0] v);
    int unsigned r;
    r = 0;
    for (int b = 0; b < REQ_W; b++) if (v[b]) r = b + 1;
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] sat_count(logic [REQ_W-1:0] v, logic [PSC_W-1:0] c);
    logic [REQ_W-1:0] s;
    s = v >> {c, 1'b0};
    if (s > REQ_W'({CNT_W{1'b1}})) return '1;
    return s[CNT_W-1:0];
  endfunction

  logic [REQ_W-1:0] coarse;
  logic [PSC_W-1:0] need;
  logic [CNT_W-1:0] high_raw;
  int unsigned      half;

  assign coarse = req_period >> CNT_W;

  always_comb begin
    half = (msb_index(coarse) + 1) / 2;
    if (half > CODE_MAX) need = PSC_W'(CODE_MAX);
    else                 need = PSC_W'(half);
  end

  assign busy_o   = shared && (need > cur_code);
  assign code_o   = shared ? cur_code : need;
  assign per_o    = sat_count(req_period, code_o);
  assign high_raw = sat_count(req_high, code_o);
  assign high_o   = (high_raw > per_o) ? per_o : high_raw;

  // R10: reported high time never exceeds reported period
  a_r10_duty_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    high_o <= per_o);
  // R11: busy only arises when the divider is shared
  a_r11_busy_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (shared && code_o == cur_code));
endmodule

// File: rtl/pwm2_timer.sv
module pwm2_timer #(
  parameter int CNT_W = pwm2_pkg::CNT_W,
  parameter int PSC_W = pwm2_pkg::PSC_W,
  parameter int REQ_W = pwm2_pkg::REQ_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [PSC_W-1:0] ctl_prescale,
  input  logic             ctl_clr_on_c,
  input  logic             ctl_run,
  input  logic             cmp_we,
  input  logic [1:0]       cmp_addr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [1:0]       out_en,
  input  logic [REQ_W-1:0] req_period,
  input  logic [REQ_W-1:0] req_duty,
  output logic [PSC_W-1:0] calc_code,
  output logic [CNT_W-1:0] calc_period,
  output logic [CNT_W-1:0] calc_duty,
  output logic             calc_busy,
  output logic [CNT_W-1:0] count,
  output logic [1:0]       pwm_out
);
  localparam int NOUT  = pwm2_pkg::NOUT;
  localparam int DIV_W = 2 * ((1 << PSC_W) - 1);

  logic [PSC_W-1:0]           psc_q;
  logic                       clrc_q;
  logic                       run_q;
  logic                       running;
  logic                       ctl_diff;
  logic                       restart;
  logic                       tick;
  logic                       wrap;
  logic [NOUT-1:0][CNT_W-1:0] per_live, high_live;

  assign running  = run_q && (|out_en);
  assign ctl_diff = (ctl_prescale != psc_q) || (ctl_clr_on_c != clrc_q) || (ctl_run != run_q);
  assign restart  = ctl_we && ctl_diff && running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_q  <= '0;
      clrc_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (ctl_we) begin
      psc_q  <= ctl_prescale;
      clrc_q <= ctl_clr_on_c;
      run_q  <= ctl_run;
    end
  end

  pwm2_prescaler #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (running && !restart),
    .code   (psc_q),
    .tick   (tick)
  );

  pwm2_counter #(.CNT_W(CNT_W), .NOUT(NOUT)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_we    (cmp_we),
    .cmp_addr  (cmp_addr),
    .cmp_wdata (cmp_wdata),
    .running   (running),
    .restart   (restart),
    .tick      (tick),
    .clr_on_c  (clrc_q),
    .cnt_o     (count),
    .per_o     (per_live),
    .high_o    (high_live),
    .wrap_o    (wrap)
  );

  pwm2_outstage #(.CNT_W(CNT_W), .NOUT(NOUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (count),
    .running (running),
    .en      (out_en),
    .per     (per_live),
    .high    (high_live),
    .pwm     (pwm_out)
  );

  pwm2_calc #(.CNT_W(CNT_W), .PSC_W(PSC_W), .REQ_W(REQ_W)) u_calc (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_period (req_period),
    .req_high   (req_duty),
    .cur_code   (psc_q),
    .shared     (&out_en),
    .code_o     (calc_code),
    .per_o      (calc_period),
    .high_o     (calc_duty),
    .busy_o     (calc_busy)
  );

  // R8: a control change while running restarts the counter from zero
  a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == '0);
  // R2: a wrap is always followed by a zero count
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0);
endmodule

// File: tb/pwm2_timer_tb.sv
module pwm2_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_prescale = '0;
  logic        ctl_clr_on_c = 1'b0;
  logic        ctl_run = 1'b0;
  logic        cmp_we = 1'b0;
  logic [1:0]  cmp_addr = '0;
  logic [15:0] cmp_wdata = '0;
  logic [1:0]  out_en = '0;
  logic [31:0] req_period = '0;
  logic [31:0] req_duty = '0;
  logic [1:0]  calc_code;
  logic [15:0] calc_period, calc_duty, count;
  logic        calc_busy;
  logic [1:0]  pwm_out;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm2_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_prescale(ctl_prescale),
    .ctl_clr_on_c(ctl_clr_on_c), .ctl_run(ctl_run), .cmp_we(cmp_we),
    .cmp_addr(cmp_addr), .cmp_wdata(cmp_wdata), .out_en(out_en),
    .req_period(req_period), .req_duty(req_duty), .calc_code(calc_code),
    .calc_period(calc_period), .calc_duty(calc_duty), .calc_busy(calc_busy),
    .count(count), .pwm_out(pwm_out)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ctl_write(int c, bit clrc, bit run);
    @(negedge clk);
    ctl_prescale = 2'(c); ctl_clr_on_c = clrc; ctl_run = run; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic cmp_write(int a, int v);
    @(negedge clk);
    cmp_addr = 2'(a); cmp_wdata = 16'(v); cmp_we = 1'b1;
    @(negedge clk);
    cmp_we = 1'b0;
  endtask

  task automatic configure(int c, int pa, int da, int pc, int dc, bit clrc, logic [1:0] en);
    ctl_write(c, clrc, 0);
    cmp_write(0, pa); cmp_write(1, da); cmp_write(2, pc); cmp_write(3, dc);
    out_en = en;
    @(negedge clk);
    ctl_write(c, clrc, 1);
  endtask

  // starts at the first negedge after the starting edge (n = 0)
  task automatic check_window(int ncyc, int c, int pa, int da, int pc, int dc,
                              bit clrc, logic [1:0] en, string tag);
    int top;
    top = clrc ? pc : pa;
    for (int n = 0; n < ncyc; n++) begin
      int ce;
      bit e0, e1;
      ce = (n >> (2 * c)) % (top + 1);
      e0 = en[0] && ((da >= pa) || (ce < da));
      e1 = en[1] && ((dc >= pc) || (ce < dc));
      chk(count == 16'(ce), tag, "count", count, ce);
      chk(pwm_out == {e1, e0}, tag, "pwm_out", pwm_out, {e1, e0});
      @(negedge clk);
    end
  endtask

  task automatic calc_model(logic [31:0] rp, logic [31:0] rd, int cur, bit both,
                            output int code, output longint per, output longint dut, output bit busy);
    longint q;
    int hb, need;
    q = longint'(rp) / 65536;
    hb = 0;
    while (q > 0) begin hb++; q = q / 2; end
    need = (hb + 1) / 2;
    if (need > 3) need = 3;
    busy = both && (need > cur);
    code = both ? cur : need;
    per = longint'(rp) / (longint'(1) << (2 * code));
    if (per > 65535) per = 65535;
    dut = longint'(rd) / (longint'(1) << (2 * code));
    if (dut > 65535) dut = 65535;
    if (dut > per) dut = per;
  endtask

  task automatic calc_check(logic [31:0] rp, logic [31:0] rd, int cur, logic [1:0] en);
    int ec; longint ep, ed; bit eb;
    out_en = en;
    ctl_write(cur, 0, 0);
    req_period = rp; req_duty = rd;
    #1;
    calc_model(rp, rd, cur, &en, ec, ep, ed, eb);
    chk(calc_code == 2'(ec), "R9", "calc_code", calc_code, ec);
    chk(calc_period == 16'(ep), "R10", "calc_period", calc_period, ep);
    chk(calc_duty == 16'(ed), "R10", "calc_duty", calc_duty, ed);
    chk(calc_busy == eb, "R11", "calc_busy", calc_busy, eb);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2741));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(count == 16'd0, "R1", "count", count, 0);
    chk(pwm_out == 2'b00, "R1", "pwm_out", pwm_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == 16'd0, "R1", "count after release", count, 0);

    // R2 R3 R4: directed waveforms at several divider codes
    configure(0, 9, 4, 6, 2, 0, 2'b11);
    check_window(40, 0, 9, 4, 6, 2, 0, 2'b11, "R2/R4");
    configure(1, 5, 2, 0, 0, 0, 2'b01);
    check_window(60, 1, 5, 2, 0, 0, 0, 2'b01, "R3");
    configure(2, 3, 1, 0, 0, 0, 2'b01);
    check_window(80, 2, 3, 1, 0, 0, 0, 2'b01, "R3");
    // R2 R4: clear on C, high time above period, high time zero
    configure(0, 20, 25, 7, 0, 1, 2'b11);
    check_window(40, 0, 20, 25, 7, 0, 1, 2'b11, "R2/R4");
    configure(0, 6, 6, 5, 3, 1, 2'b11);
    check_window(30, 0, 6, 6, 5, 3, 1, 2'b11, "R4");
    // R6: output 0 disabled while output 1 runs
    configure(0, 5, 3, 5, 2, 0, 2'b10);
    check_window(30, 0, 5, 3, 5, 2, 0, 2'b10, "R6");

    // random waveforms
    for (int k = 0; k < 6; k++) begin
      int c, pa, da, pc, dc; bit clrc; logic [1:0] en;
      c = $urandom % 2; pa = 1 + $urandom % 12; da = $urandom % 15;
      pc = 1 + $urandom % 12; dc = $urandom % 15; clrc = 1'($urandom % 2);
      en = 2'(1 + $urandom % 3);
      configure(c, pa, da, pc, dc, clrc, en);
      check_window(50, c, pa, da, pc, dc, clrc, en, "R2/R3/R4");
    end

    // R5: high-time write mid-period waits for the wrap
    configure(0, 9, 3, 0, 0, 0, 2'b01);
    for (int n = 0; n < 30; n++) begin
      int ce; bit e0;
      if (n == 1) begin cmp_addr = 2'd1; cmp_wdata = 16'd8; cmp_we = 1'b1; end
      if (n == 2) cmp_we = 1'b0;
      ce = n % 10;
      e0 = ce < ((n < 10) ? 3 : 8);
      chk(count == 16'(ce), "R5", "count", count, ce);
      chk(pwm_out[0] == e0, "R5", "pwm_out[0]", pwm_out[0], e0);
      @(negedge clk);
    end

    // R8: divider change while running restarts cleanly
    configure(0, 7, 3, 0, 0, 0, 2'b01);
    check_window(13, 0, 7, 3, 0, 0, 0, 2'b01, "R8");
    ctl_write(1, 0, 1);
    check_window(40, 1, 7, 3, 0, 0, 0, 2'b01, "R8");
    // R8: clear-source change while running
    configure(0, 9, 4, 4, 2, 0, 2'b11);
    check_window(7, 0, 9, 4, 4, 2, 0, 2'b11, "R8");
    ctl_write(0, 1, 1);
    check_window(20, 0, 9, 4, 4, 2, 1, 2'b11, "R8");

    // R7: both outputs disabled with run set
    out_en = 2'b00;
    @(negedge clk);
    for (int n = 0; n < 10; n++) begin
      chk(count == 16'd0, "R7", "count", count, 0);
      chk(pwm_out == 2'b00, "R7", "pwm_out", pwm_out, 0);
      @(negedge clk);
    end
    ctl_write(0, 0, 0);

    // R9 R10 R11: helper corners
    calc_check(32'h0000_0000, 32'h0, 0, 2'b01);
    calc_check(32'h0000_FFFF, 32'h0000_8000, 0, 2'b01);
    calc_check(32'h0001_0000, 32'h0002_0000, 0, 2'b01);
    calc_check(32'h000F_FFFF, 32'h0000_1000, 0, 2'b10);
    calc_check(32'h0010_0000, 32'h0010_0000, 0, 2'b01);
    calc_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2'b01);
    calc_check(32'h0010_0000, 32'h0000_0100, 1, 2'b11);
    calc_check(32'h0000_1000, 32'h0000_0800, 2, 2'b11);
    calc_check(32'h0004_0000, 32'h0000_0800, 2, 2'b11);
    for (int k = 0; k < 200; k++) begin
      logic [31:0] rp, rd;
      rp = $urandom >> ($urandom % 32);
      rd = $urandom >> ($urandom % 32);
      calc_check(rp, rd, $urandom % 4, 2'($urandom % 4));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule